// File: doc/BRIEF.md
# Shared Interrupt Line Aggregator

This block merges level-sensitive interrupt requests from a set of device slots onto four shared interrupt lines. Each slot has four request pins. Every pin is routed to one of the shared lines by a fixed rotation that depends on the slot number, so the load spreads across the lines.

The block does not OR the pins together. It keeps the last level seen on every pin and reacts only when a level changes. A rising pin adds one to the counter of its routed line, and a falling pin subtracts one. A line output is high whenever its counter is nonzero. Because every line has a counter, the number of devices currently asserting that line is available as an output.

All changes seen in one cycle, including several on the same line, are folded into a single counter update per line in that cycle. The counters and the outputs change on the clock edge after the input change.

Top module: `irq_line_merge`

## Requirements
- R1: Pin p of slot d (bit index d*4+p of `reqLevel`, p in 0..3) is routed to line (p + d) mod 4.
- R2: When no pin level differs from its stored level, every line counter keeps its value.
- R3: A pin going 0 to 1 adds one to its routed line counter, and a pin going 1 to 0 subtracts one. The new value appears one clock edge after the input change.
- R4: `lineActive[l]` is 1 exactly when counter l is nonzero.
- R5: Any number of simultaneous rises and falls, on the same line or on different lines, are all applied in the same cycle, and none is lost.
- R6: A synchronous active-high `rst` clears all stored levels and all counters to zero. Pins that are high when reset is released count as rises on the next edge.
- R7: Each counter is CNT_W bits wide (default 6), counter l sits at bits [l*CNT_W +: CNT_W] of `lineCount`, and it never underflows or overflows. With all pins high, every counter reads NUM_DEV (32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqLevel | input | NUM_DEV*4 | Request level of every pin, slot d pin p at bit d*4+p |
| lineActive | output | 4 | Shared line levels, one bit per line |
| lineCount | output | 4*CNT_W | Number of pins currently asserting each line |

## Verification
The bench goes after the following corner cases, each paired with the failure it would expose:
- A single pin on an odd-numbered slot. A wrong rotation would raise the wrong line.
- Pins held steady for many cycles. A design that counts levels instead of changes would keep climbing.
- Many rises and falls landing on one line in the same cycle. A design that applies only one event per cycle would drift from the true count.
- Pins left high through reset. A design that does not clear its stored levels would never count them after release.
- Every pin high, then every pin low at once. A design with a narrow counter or a lost event would fail to reach 32 or would leave a line stuck high.

// File: rtl/irq_merge_pkg.sv
package irq_merge_pkg;
  localparam int LINES = 4;
  localparam int PINS_PER_DEV = 4;

  typedef struct packed {
    logic [LINES-1:0] touch;
    logic             clear;
  } mergeStrobe_t;
endpackage

// File: rtl/irq_merge_ctrl.sv
module irq_merge_ctrl
  import irq_merge_pkg::*;
#(
  parameter int NUM_DEV = 32,
  parameter int SUM_W   = $clog2(NUM_DEV + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_DEV*PINS_PER_DEV-1:0] reqLevel,
  output mergeStrobe_t                  strb,
  output logic [LINES-1:0][SUM_W-1:0]   riseSum,
  output logic [LINES-1:0][SUM_W-1:0]   fallSum
);
  localparam int NPIN = NUM_DEV * PINS_PER_DEV;

  logic [NPIN-1:0] lastLevel;
  logic [NPIN-1:0] changed;
  logic [LINES-1:0][NUM_DEV-1:0] riseVec;
  logic [LINES-1:0][NUM_DEV-1:0] fallVec;

  always_ff @(posedge clk) begin
    if (rst) lastLevel <= '0;
    else     lastLevel <= reqLevel;
  end

  assign changed = reqLevel ^ lastLevel;

  // Route: line = (pin + dev) mod 4, hence pin = (line - dev) mod 4.
  for (genvar l = 0; l < LINES; l++) begin : g_line
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      localparam int P = (l + LINES - (d % LINES)) % LINES;
      assign riseVec[l][d] = changed[d*PINS_PER_DEV+P] &  reqLevel[d*PINS_PER_DEV+P];
      assign fallVec[l][d] = changed[d*PINS_PER_DEV+P] & ~reqLevel[d*PINS_PER_DEV+P];
    end
    assign riseSum[l]    = SUM_W'($countones(riseVec[l]));
    assign fallSum[l]    = SUM_W'($countones(fallVec[l]));
    assign strb.touch[l] = |(riseVec[l] | fallVec[l]);
  end

  assign strb.clear = rst;

  // R6: stored levels are clear on the cycle after a reset
  p_levels_cleared_r6: assert property (@(posedge clk) rst |=> (lastLevel == '0));
endmodule

// File: rtl/irq_merge_dp.sv
module irq_merge_dp
  import irq_merge_pkg::*;
#(
  parameter int NUM_DEV = 32,
  parameter int SUM_W   = $clog2(NUM_DEV + 1),
  parameter int CNT_W   = 6
) (
  input  logic                        clk,
  input  mergeStrobe_t                strb,
  input  logic [LINES-1:0][SUM_W-1:0] riseSum,
  input  logic [LINES-1:0][SUM_W-1:0] fallSum,
  output logic [LINES-1:0][CNT_W-1:0] count,
  output logic [LINES-1:0]            active
);
  localparam logic [CNT_W:0] MAXV = {1'b0, {CNT_W{1'b1}}};

  for (genvar l = 0; l < LINES; l++) begin : g_cnt
    logic [CNT_W:0] upWide;
    assign upWide = {1'b0, count[l]} + (CNT_W+1)'(riseSum[l]);

    always_ff @(posedge clk) begin
      if (strb.clear)          count[l] <= '0;
      else if (strb.touch[l])  count[l] <= count[l] + CNT_W'(riseSum[l]) - CNT_W'(fallSum[l]);
    end

    assign active[l] = (count[l] != '0);

    // R7: no counter underflow or overflow
    p_no_underflow_r7: assert property (@(posedge clk) disable iff (strb.clear)
      strb.touch[l] |-> (upWide >= (CNT_W+1)'(fallSum[l])));
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (strb.clear)
      strb.touch[l] |-> ((upWide - (CNT_W+1)'(fallSum[l])) <= MAXV));
    // R2: an untouched line holds its count
    p_hold_r2: assert property (@(posedge clk) disable iff (strb.clear)
      !strb.touch[l] |=> $stable(count[l]));
    // R4: a line can only come up after a rise routed to it
    p_rise_cause_r4: assert property (@(posedge clk) disable iff (strb.clear)
      $rose(active[l]) |-> $past(riseSum[l] != '0));
    // R3: a cycle with net rises increases the count
    p_net_up_r3: assert property (@(posedge clk) disable iff (strb.clear)
      (strb.touch[l] && riseSum[l] > fallSum[l]) |=> (count[l] > $past(count[l])));
  end
endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge
  import irq_merge_pkg::*;
#(
  parameter int NUM_DEV = 32,
  parameter int CNT_W   = 6
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_DEV*PINS_PER_DEV-1:0] reqLevel,
  output logic [LINES-1:0]                lineActive,
  output logic [LINES*CNT_W-1:0]          lineCount
);
  localparam int SUM_W = $clog2(NUM_DEV + 1);

  mergeStrobe_t                strb;
  logic [LINES-1:0][SUM_W-1:0] riseSum;
  logic [LINES-1:0][SUM_W-1:0] fallSum;
  logic [LINES-1:0][CNT_W-1:0] count;

  irq_merge_ctrl #(.NUM_DEV(NUM_DEV), .SUM_W(SUM_W)) u_ctrl (
    .clk(clk), .rst(rst), .reqLevel(reqLevel),
    .strb(strb), .riseSum(riseSum), .fallSum(fallSum));

  irq_merge_dp #(.NUM_DEV(NUM_DEV), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .strb(strb), .riseSum(riseSum), .fallSum(fallSum),
    .count(count), .active(lineActive));

  assign lineCount = count;
endmodule

// File: tb/sim_irq_line_merge.sv
`timescale 1ns/1ps
module sim_irq_line_merge;
  localparam int NUM_DEV = 32;
  localparam int CNT_W   = 6;
  localparam int NPIN    = NUM_DEV * 4;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [NPIN-1:0]    reqLevel = '0;
  logic [3:0]         lineActive;
  logic [4*CNT_W-1:0] lineCount;

  int total = 0;
  int bad   = 0;

  irq_line_merge #(.NUM_DEV(NUM_DEV), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .reqLevel(reqLevel),
    .lineActive(lineActive), .lineCount(lineCount));

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive after a falling edge; compare at the next falling edge,
  // one rising edge later, against a recount of the driven levels.
  task automatic apply(input logic [NPIN-1:0] v, input logic r, input string req);
    int exp [4];
    reqLevel = v;
    rst      = r;
    @(negedge clk);
    for (int l = 0; l < 4; l++) exp[l] = 0;
    if (!r)
      for (int d = 0; d < NUM_DEV; d++)
        for (int p = 0; p < 4; p++)
          if (v[d*4+p]) exp[(p + d) % 4]++;
    for (int l = 0; l < 4; l++) begin
      check(req, int'(lineCount[l*CNT_W +: CNT_W]), exp[l]);
      check({req, "/R4"}, int'(lineActive[l]), (exp[l] != 0) ? 1 : 0);
    end
  endtask

  initial begin
    #(2_000_000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NPIN-1:0] v;
    @(negedge clk);
    apply('0, 1'b1, "R6 reset");
    apply('1, 1'b1, "R6 held in reset");
    apply('1, 1'b0, "R6 release counts high pins");
    apply('1, 1'b0, "R7 all high gives 32");
    apply('0, 1'b0, "R5 all fall at once");
    v = '0; v[5*4+2] = 1'b1;                  // slot 5 pin 2 -> line 3
    apply(v, 1'b0, "R1 slot5 pin2");
    for (int i = 0; i < 5; i++) apply(v, 1'b0, "R2 steady");
    apply('0, 1'b0, "R3 single fall");
    v = '0; v[3*4+0] = 1'b1;                  // slot 3 pin 0 -> line 3
    apply(v, 1'b0, "R1 slot3 pin0");
    v[0*4+3] = 1'b1; v[1*4+2] = 1'b1; v[2*4+1] = 1'b1;  // all to line 3
    apply(v, 1'b0, "R5 same line rises");
    v[3*4+0] = 1'b0; v[4*4+3] = 1'b1;        // one fall, one rise on line 3
    apply(v, 1'b0, "R5 rise and fall together");
    for (int i = 0; i < 200; i++) begin
      v = {$urandom(), $urandom(), $urandom(), $urandom()};
      apply(v, 1'b0, "R3 random");
    end
    apply(v, 1'b1, "R6 mid-run reset");
    apply(v, 1'b0, "R6 recount after reset");
    apply('0, 1'b0, "R5 drop all");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule